// File: doc/BRIEF.md
# Beacon Timer Scheduler

The block keeps four 16-bit beacon timers that follow the running time-synchronisation counter (TSF). Two timers count in time units (TU, TSF bits from bit 10 upward): the next beacon target and the end of the announcement (ATIM) window. The other two count in eighths of a TU (TSF bits from bit 7 upward): the DMA beacon alert, which doubles as the wakeup timer in station mode, and the software beacon alert, which doubles as the contention-free-period start. When a timer's value equals the matching 16-bit slice of the TSF, the block raises a one-cycle pulse for that timer and moves the timer forward by one beacon interval.

An init strobe loads all four timers from a next-beacon time, a beacon interval and an operating mode. Each timer advances only on an exact match. If the TSF jumps past a stored value, that timer is left behind until the 16-bit count wraps and reaches the value again. A registered consistency flag reports whether the ATIM end and the DMA alert still sit at their intended distance from the next beacon. The check tolerates 16-bit wrap, and it tolerates timers that have each advanced a different number of times.

Top module: `beacon_sched_top`

## Requirements
- R1: While reset is high and on the first cycle after it, all four timer outputs are 0, no fire pulse is high and `win_ok_o` is 0.
- R2: Modes are coded 0 station, 1 independent, 2 access point, 3 mesh. In modes 1 to 3, the cycle after an init the timers hold the following values, all truncated to 16 bits: next beacon = N (or 0 in modes 2 and 3), DMA alert = (N - DMA_RESP) * 8, software alert = (N - SW_RESP) * 8, ATIM end = N + 1.
- R3: In mode 0, the cycle after an init the timers hold: next beacon = N, DMA alert (wakeup) = N * 8, software alert (CFP start) = 0xFFFF, ATIM end = N + 1.
- R4: Once armed, a TU timer whose value equals TSF[25:10] gives a fire pulse one cycle later, and in that same cycle its value has grown by the beacon interval, modulo 2^16.
- R5: Once armed, an eighth-TU timer whose value equals TSF[22:7] gives a fire pulse one cycle later, and in that same cycle its value has grown by 8 times the interval, modulo 2^16.
- R6: Before the first init, no timer fires or changes, whatever the TSF value.
- R7: A timer whose value the TSF count skips stays unchanged and silent until the 16-bit count equals its value again, including after the count wraps.
- R8: `win_ok_o` is registered from the previous cycle's timers and interval. It is the AND of span(nbtt, atim, 1) and span(dba>>3, nbtt, DMA_RESP). span(a,b,w) holds when b-a==w, or a-b==I-w, or (a|0x10000)-b==I-w, or (b|0x10000)-a==w, computed in signed integer arithmetic.
- R9: When init coincides with a match, the loaded values win and no fire pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tsf_i | input | TSF_W | Running TSF in microseconds |
| init_i | input | 1 | Load all timers from the init fields |
| init_mode_i | input | 2 | Operating mode for the load |
| init_next_i | input | TW | Next beacon time in TU |
| init_intval_i | input | TW | Beacon interval in TU |
| fire_o | output | 4 | Per-timer match pulse: bit0 beacon, bit1 DMA alert, bit2 software alert, bit3 ATIM end |
| tmr_nbtt_o | output | TW | Next beacon timer (TU) |
| tmr_dba_o | output | TW | DMA alert or wakeup timer (1/8 TU) |
| tmr_swba_o | output | TW | Software alert or CFP timer (1/8 TU) |
| tmr_atim_o | output | TW | ATIM window end timer (TU) |
| win_ok_o | output | 1 | Timer spacing consistent |

## Verification
A timer that advances by the wrong step, or on a cycle with no match, shows at its own output on the very next cycle. It then shows as a fire pulse that is missing or misplaced when the TSF next reaches the expected value. It also pulls `win_ok_o` low one cycle later. A wrong slice of the TSF moves every pulse of one timer class. The cycle-by-cycle sweep across several beacon periods catches this within one eighth of a TU. A stranded timer that fails to stay silent fires early during the jump and wrap sequence.

// File: rtl/bsched_pkg.sv
package bsched_pkg;
  typedef enum logic [1:0] {
    MODE_STA  = 2'd0,
    MODE_IBSS = 2'd1,
    MODE_AP   = 2'd2,
    MODE_MESH = 2'd3
  } bs_mode_e;

  localparam int NUM_TMR  = 4;
  localparam int TMR_NBTT = 0;
  localparam int TMR_DBA  = 1;
  localparam int TMR_SWBA = 2;
  localparam int TMR_ATIM = 3;
endpackage

// File: rtl/bsched_init.sv
module bsched_init
  import bsched_pkg::*;
#(
  parameter int TW         = 16,
  parameter int FRAC_SHIFT = 3,
  parameter int DMA_RESP   = 2,
  parameter int SW_RESP    = 10
) (
  input  bs_mode_e                     mode,
  input  logic [TW-1:0]                next_tu,
  output logic [NUM_TMR-1:0][TW-1:0]   vals
);
  logic [TW-1:0] dba_tu;
  logic [TW-1:0] swba_tu;

  always_comb begin
    dba_tu  = next_tu - TW'(DMA_RESP);
    swba_tu = next_tu - TW'(SW_RESP);
    vals[TMR_ATIM] = next_tu + TW'(1);
    case (mode)
      MODE_STA: begin
        vals[TMR_NBTT] = next_tu;
        vals[TMR_DBA]  = next_tu << FRAC_SHIFT;
        vals[TMR_SWBA] = '1;
      end
      MODE_IBSS: begin
        vals[TMR_NBTT] = next_tu;
        vals[TMR_DBA]  = dba_tu << FRAC_SHIFT;
        vals[TMR_SWBA] = swba_tu << FRAC_SHIFT;
      end
      default: begin
        vals[TMR_NBTT] = '0;
        vals[TMR_DBA]  = dba_tu << FRAC_SHIFT;
        vals[TMR_SWBA] = swba_tu << FRAC_SHIFT;
      end
    endcase
  end
endmodule

// File: rtl/bsched_timer.sv
module bsched_timer #(
  parameter int TW         = 16,
  parameter int STEP_SHIFT = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  input  logic [TW-1:0] cnt,
  input  logic [TW-1:0] intval,
  output logic [TW-1:0] val_q,
  output logic          fire_q
);
  logic [TW-1:0] step;
  logic          match;

  assign step  = intval << STEP_SHIFT;
  assign match = en && !load && (cnt == val_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      val_q  <= '0;
      fire_q <= 1'b0;
    end else begin
      fire_q <= match;
      if (load)
        val_q <= load_val;
      else if (match)
        val_q <= val_q + step;
    end
  end

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(load)) |-> (val_q == $past(load_val) && !fire_q)); // R9
  AST_ADVANCE_ON_FIRE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && fire_q) |-> (val_q == $past(val_q) + $past(step))); // R4
  AST_HOLD_UNLESS_FIRE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(load) && !fire_q) |-> $stable(val_q)); // R7
  AST_SILENT_UNARMED: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(en)) |-> !fire_q); // R6
endmodule

// File: rtl/bsched_wincheck.sv
module bsched_wincheck #(
  parameter int TW         = 16,
  parameter int FRAC_SHIFT = 3,
  parameter int DMA_RESP   = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [TW-1:0] nbtt,
  input  logic [TW-1:0] dba,
  input  logic [TW-1:0] atim,
  input  logic [TW-1:0] intval,
  output logic          ok_q
);
  localparam int WRAP = 1 << TW;

  function automatic logic span_ok(input int a, input int b, input int w, input int iv);
    return (b - a == w) || (a - b == iv - w) ||
           ((a | WRAP) - b == iv - w) || ((b | WRAP) - a == w);
  endfunction

  logic [TW-1:0] dba_tu;
  logic          ok_d;

  always_comb begin
    dba_tu = dba >> FRAC_SHIFT;
    ok_d = span_ok(int'(nbtt), int'(atim), 1, int'(intval)) &&
           span_ok(int'(dba_tu), int'(nbtt), DMA_RESP, int'(intval));
  end

  always_ff @(posedge clk) begin
    if (rst) ok_q <= 1'b0;
    else     ok_q <= ok_d;
  end
endmodule

// File: rtl/beacon_sched_top.sv
module beacon_sched_top
  import bsched_pkg::*;
#(
  parameter int TSF_W      = 64,
  parameter int TW         = 16,
  parameter int TU_SHIFT   = 10,
  parameter int FRAC_SHIFT = 3,
  parameter int DMA_RESP   = 2,
  parameter int SW_RESP    = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [TSF_W-1:0] tsf_i,
  input  logic             init_i,
  input  logic [1:0]       init_mode_i,
  input  logic [TW-1:0]    init_next_i,
  input  logic [TW-1:0]    init_intval_i,
  output logic [3:0]       fire_o,
  output logic [TW-1:0]    tmr_nbtt_o,
  output logic [TW-1:0]    tmr_dba_o,
  output logic [TW-1:0]    tmr_swba_o,
  output logic [TW-1:0]    tmr_atim_o,
  output logic             win_ok_o
);
  localparam int FRAC_UNIT_SHIFT = TU_SHIFT - FRAC_SHIFT;

  logic [TW-1:0]              tu_cnt;
  logic [TW-1:0]              fr_cnt;
  logic                       tsf_unused;
  logic [NUM_TMR-1:0][TW-1:0] init_vals;
  logic [NUM_TMR-1:0][TW-1:0] tmr_q;
  logic [TW-1:0]              intval_q;
  logic                       armed_q;

  assign tu_cnt     = tsf_i[TU_SHIFT +: TW];
  assign fr_cnt     = tsf_i[FRAC_UNIT_SHIFT +: TW];
  assign tsf_unused = ^{tsf_i[FRAC_UNIT_SHIFT-1:0], tsf_i[TSF_W-1:TU_SHIFT+TW]};

  always_ff @(posedge clk) begin
    if (rst) begin
      intval_q <= '0;
      armed_q  <= 1'b0;
    end else if (init_i) begin
      intval_q <= init_intval_i;
      armed_q  <= 1'b1;
    end
  end

  bsched_init #(
    .TW(TW), .FRAC_SHIFT(FRAC_SHIFT), .DMA_RESP(DMA_RESP), .SW_RESP(SW_RESP)
  ) u_init (
    .mode    (bs_mode_e'(init_mode_i)),
    .next_tu (init_next_i),
    .vals    (init_vals)
  );

  for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
    localparam bit FRAC = (g == TMR_DBA) || (g == TMR_SWBA);
    bsched_timer #(
      .TW(TW), .STEP_SHIFT(FRAC ? FRAC_SHIFT : 0)
    ) u_tmr (
      .clk      (clk),
      .rst      (rst),
      .en       (armed_q),
      .load     (init_i),
      .load_val (init_vals[g]),
      .cnt      (FRAC ? fr_cnt : tu_cnt),
      .intval   (intval_q),
      .val_q    (tmr_q[g]),
      .fire_q   (fire_o[g])
    );
  end

  bsched_wincheck #(
    .TW(TW), .FRAC_SHIFT(FRAC_SHIFT), .DMA_RESP(DMA_RESP)
  ) u_win (
    .clk    (clk),
    .rst    (rst),
    .nbtt   (tmr_q[TMR_NBTT]),
    .dba    (tmr_q[TMR_DBA]),
    .atim   (tmr_q[TMR_ATIM]),
    .intval (intval_q),
    .ok_q   (win_ok_o)
  );

  assign tmr_nbtt_o = tmr_q[TMR_NBTT];
  assign tmr_dba_o  = tmr_q[TMR_DBA];
  assign tmr_swba_o = tmr_q[TMR_SWBA];
  assign tmr_atim_o = tmr_q[TMR_ATIM];

  AST_ATIM_FOLLOWS_BEACON: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(init_i) && ($past(init_mode_i) < 2'd2)) |->
      (tmr_atim_o == tmr_nbtt_o + TW'(1))); // R2
  AST_NO_FIRE_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (fire_o == 4'b0 && !win_ok_o)); // R1
endmodule

// File: tb/test_beacon_sched_top.sv
`timescale 1ns/1ps
module test_beacon_sched_top;
  localparam int DMA = 2;
  localparam int SWR = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] tsf_i = '0;
  logic        init_i = 1'b0;
  logic [1:0]  init_mode_i = '0;
  logic [15:0] init_next_i = '0;
  logic [15:0] init_intval_i = '0;
  logic [3:0]  fire_o;
  logic [15:0] tmr_nbtt_o, tmr_dba_o, tmr_swba_o, tmr_atim_o;
  logic        win_ok_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [15:0] exp_t [4];
  logic [15:0] exp_iv = '0;
  logic        armed = 1'b0;

  always #2 clk = ~clk;

  beacon_sched_top i_beacon_sched_top (
    .clk(clk), .rst(rst), .tsf_i(tsf_i), .init_i(init_i),
    .init_mode_i(init_mode_i), .init_next_i(init_next_i),
    .init_intval_i(init_intval_i), .fire_o(fire_o),
    .tmr_nbtt_o(tmr_nbtt_o), .tmr_dba_o(tmr_dba_o),
    .tmr_swba_o(tmr_swba_o), .tmr_atim_o(tmr_atim_o), .win_ok_o(win_ok_o)
  );

  task automatic check(input bit good, input string tag, input longint act, input longint expv);
    n_chk++;
    if (!good) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  function automatic bit span(input int a, input int b, input int w, input int iv);
    return (b - a == w) || (a - b == iv - w) ||
           ((a | 65536) - b == iv - w) || ((b | 65536) - a == w);
  endfunction

  task automatic cyc(input logic [63:0] t, input bit ini, input logic [1:0] md,
                     input logic [15:0] nx, input logic [15:0] iv, input string tag);
    logic [3:0]  ef;
    bit          ok_e;
    logic [15:0] c;
    logic [15:0] st;
    tsf_i = t; init_i = ini; init_mode_i = md; init_next_i = nx; init_intval_i = iv;
    ok_e = span(int'(exp_t[0]), int'(exp_t[3]), 1, int'(exp_iv)) &&
           span(int'(exp_t[1] >> 3), int'(exp_t[0]), DMA, int'(exp_iv));
    ef = '0;
    if (ini) begin
      exp_t[0] = (md >= 2'd2) ? 16'd0 : nx;
      exp_t[1] = (md == 2'd0) ? (nx << 3) : ((nx - 16'(DMA)) << 3);
      exp_t[2] = (md == 2'd0) ? 16'hFFFF : ((nx - 16'(SWR)) << 3);
      exp_t[3] = nx + 16'd1;
      exp_iv = iv;
      armed = 1'b1;
    end else begin
      for (int i = 0; i < 4; i++) begin
        c  = (i == 1 || i == 2) ? t[22:7] : t[25:10];
        st = (i == 1 || i == 2) ? {exp_iv[12:0], 3'b000} : exp_iv;
        if (armed && c == exp_t[i]) begin
          ef[i] = 1'b1;
          exp_t[i] = exp_t[i] + st;
        end
      end
    end
    @(posedge clk);
    @(negedge clk);
    init_i = 1'b0;
    check(fire_o == ef, {tag, " fire"}, fire_o, ef);
    check(tmr_nbtt_o == exp_t[0], {tag, " nbtt"}, tmr_nbtt_o, exp_t[0]);
    check(tmr_dba_o  == exp_t[1], {tag, " dba"},  tmr_dba_o,  exp_t[1]);
    check(tmr_swba_o == exp_t[2], {tag, " swba"}, tmr_swba_o, exp_t[2]);
    check(tmr_atim_o == exp_t[3], {tag, " atim"}, tmr_atim_o, exp_t[3]);
    check(win_ok_o == ok_e, "R8 win_ok", win_ok_o, ok_e);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [15:0] nexts [5];
    nexts[0] = 16'd100; nexts[1] = 16'd5; nexts[2] = 16'd1500;
    nexts[3] = 16'd8191; nexts[4] = 16'd65535;
    for (int i = 0; i < 4; i++) exp_t[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(fire_o == 4'b0, "R1 fire", fire_o, 0);
    check({tmr_nbtt_o, tmr_dba_o, tmr_swba_o, tmr_atim_o} == '0, "R1 timers",
          {tmr_nbtt_o, tmr_dba_o, tmr_swba_o, tmr_atim_o}, 0);
    check(win_ok_o == 1'b0, "R1 win_ok", win_ok_o, 0);
    // R6 unarmed: TSF sweeps over the zero timers without effect
    for (int k = 0; k < 6; k++) cyc(64'(k) << 7, 1'b0, 2'd0, 16'd0, 16'd0, "R6");
    // R2 / R3 init values across all modes and several next-beacon times
    for (int m = 0; m < 4; m++) begin
      for (int j = 0; j < 5; j++) begin
        cyc(64'd0, 1'b1, 2'(m), nexts[j], 16'd100, (m == 0) ? "R3" : "R2");
        cyc(64'd0, 1'b0, 2'(m), 16'd0, 16'd0, (m == 0) ? "R3" : "R2");
      end
    end
    // R4 R5 sweep in eighth-TU steps across two beacon periods
    cyc(64'd89 << 10, 1'b1, 2'd1, 16'd100, 16'd100, "R2");
    for (int u = 90 * 8; u <= 320 * 8; u++) cyc(64'(u) << 7, 1'b0, 2'd1, 16'd0, 16'd0, "R4 R5");
    // R7 jump past the beacon, then wrap the 16-bit TU count back onto it
    cyc(64'd999 << 10, 1'b1, 2'd1, 16'd1000, 16'd100, "R2");
    cyc(64'd1001 << 10, 1'b0, 2'd1, 16'd0, 16'd0, "R7");
    cyc(64'd1001 << 10, 1'b0, 2'd1, 16'd0, 16'd0, "R7");
    check(tmr_nbtt_o == 16'd1000, "R7 stranded", tmr_nbtt_o, 1000);
    cyc(64'd1002 << 10, 1'b0, 2'd1, 16'd0, 16'd0, "R7");
    check(win_ok_o == 1'b0, "R8 broken window", win_ok_o, 0);
    cyc(64'(1000 + 65536) << 10, 1'b0, 2'd1, 16'd0, 16'd0, "R7");
    check(tmr_nbtt_o == 16'd1100, "R7 wrap release", tmr_nbtt_o, 1100);
    cyc(64'(1000 + 65536) << 10, 1'b0, 2'd1, 16'd0, 16'd0, "R7");
    // R9 init in the same cycle as a match
    cyc(64'd1100 << 10, 1'b1, 2'd1, 16'd1100, 16'd50, "R9");
    check(fire_o == 4'b0, "R9 no fire", fire_o, 0);
    cyc(64'd1100 << 10, 1'b0, 2'd1, 16'd0, 16'd0, "R4");
    for (int u = 1100 * 8; u <= 1260 * 8; u++) cyc(64'(u) << 7, 1'b0, 2'd1, 16'd0, 16'd0, "R4 R5");
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule